// File: doc/BRIEF.md
# Auto-Detecting Multiplexed-Bus Write Register File

This block is the write-only host interface of a power-waveform generator core. A host drives an 8-bit bus that carries the address and then the data. The bus also has an address strobe, a chip select and two control lines. The block accepts either of the two common multiplexed-bus control conventions. On every bus cycle it decides which one is in use from the level of the shared read/data-strobe line at the moment the address strobe rises. If that line is high, the cycle uses read/write strobes. If it is low, the cycle uses a data strobe together with a read/not-write select.

Each data byte lands in one of three byte-wide staging registers. A write to one of two further addresses copies all three staging bytes together into a 24-bit control word or a 24-bit initialisation word. Only the fact of that write matters; its data byte is discarded. In this way the core never sees a partially updated word.

The bus strobes have no timing relation to the core clock. Every bus line is therefore passed through a two-flop synchroniser. Edges are found in the core clock domain, so both 24-bit words are driven from core-clock flops.

Top module: `mbus_regfile`

## Requirements
- R1: The bus convention is re-chosen on every rising edge of `ale_as` from the level of `rd_ds` at that edge. A high level (1) selects strobe mode, where writes are timed by `wr_rw`. A low level (0) selects data-strobe mode, where writes are timed by `rd_ds`.
- R2: The register address is `ad[2:0]` as held just before `ale_as` falls. Bits `ad[7:3]` of the address phase have no effect.
- R3: In strobe mode a write happens on the rising edge of `wr_rw` while `cs_n` is 0. A low pulse on `rd_ds` in this mode writes nothing.
- R4: In data-strobe mode a write happens on the falling edge of `rd_ds`, and only if `wr_rw` is 0 and `cs_n` is 0 at that moment. With `wr_rw` at 1 nothing is written.
- R5: Addresses 0, 1 and 2 load the data byte into staging bytes that map to bits 7:0, 15:8 and 23:16 of a committed word. Staging writes do not change `ctrl_word` or `init_word`.
- R6: A write to address 3 copies all three staging bytes into `ctrl_word` in a single clock. The data byte is ignored, the staging bytes keep their values, and the new word is visible within 8 core clocks of the write edge.
- R7: A write to address 4 copies all three staging bytes into `init_word` in a single clock. The data byte is ignored.
- R8: Writes to addresses 5, 6 and 7 change nothing. Neither does any write made while `cs_n` is 1.
- R9: Reset clears `ctrl_word`, `init_word` and all staging bytes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 8 | Multiplexed address/data bus |
| ale_as | input | 1 | Address strobe; high during the address phase |
| rd_ds | input | 1 | Read strobe (strobe mode) or data strobe (data-strobe mode) |
| wr_rw | input | 1 | Write strobe, active low (strobe mode), or read/not-write select (data-strobe mode) |
| cs_n | input | 1 | Chip select, active low |
| ctrl_word | output | 24 | Committed control word, core clock domain |
| init_word | output | 24 | Committed initialisation word, core clock domain |

## Verification
The bench mixes the two bus conventions from one cycle to the next. A design that latched the convention once, or that sampled `rd_ds` at the wrong strobe edge, would then miss or duplicate writes. Further cycles go after writes that must not take effect: a read pulse in strobe mode, `wr_rw` held high in data-strobe mode, chip select inactive, and the unused addresses. Each of these would corrupt a staging byte, and the corruption shows at the next commit. Commits carry random data bytes and random upper address bits, so a design that stored the commit byte or decoded more than three address bits would produce a wrong word. Comparing both words after every cycle exposes a commit that lands in the wrong word or that tears across the three bytes.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic {
        MODE_DSTROBE = 1'b0,
        MODE_STROBE  = 1'b1
    } bus_mode_e;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] ad_s,
    input  logic              ale_s,
    input  logic              rds_s,
    input  logic              wrw_s,
    input  logic              csn_s,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_byte
);

    typedef struct packed {
        logic [BYTE_W-1:0] prev_ad;
        logic              prev_ale;
        logic              prev_rds;
        logic              prev_wrw;
        logic              prev_csn;
        bus_mode_e         mode;
        logic [ADDR_W-1:0] addr;
        logic              stb;
        logic [ADDR_W-1:0] stb_addr;
        logic [BYTE_W-1:0] stb_byte;
    } dec_t;

    dec_t st_d, st_q;
    logic ale_rise, ale_fall, strobe_wr, dstrobe_wr;

    always_comb begin
        st_d          = st_q;
        st_d.prev_ad  = ad_s;
        st_d.prev_ale = ale_s;
        st_d.prev_rds = rds_s;
        st_d.prev_wrw = wrw_s;
        st_d.prev_csn = csn_s;
        st_d.stb      = 1'b0;

        ale_rise   = ale_s && !st_q.prev_ale;
        ale_fall   = !ale_s && st_q.prev_ale;
        strobe_wr  = (st_q.mode == MODE_STROBE) && !st_q.prev_wrw && wrw_s
                     && !st_q.prev_csn;
        dstrobe_wr = (st_q.mode == MODE_DSTROBE) && st_q.prev_rds && !rds_s
                     && !st_q.prev_wrw && !st_q.prev_csn;

        if (ale_rise) begin
            st_d.mode = rds_s ? MODE_STROBE : MODE_DSTROBE;
        end
        if (ale_fall) begin
            st_d.addr = st_q.prev_ad[ADDR_W-1:0];
        end
        if (strobe_wr || dstrobe_wr) begin
            st_d.stb      = 1'b1;
            st_d.stb_addr = st_q.addr;
            st_d.stb_byte = st_q.prev_ad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev_ad  <= '0;
            st_q.prev_ale <= 1'b0;
            st_q.prev_rds <= 1'b1;
            st_q.prev_wrw <= 1'b1;
            st_q.prev_csn <= 1'b1;
            st_q.mode     <= MODE_STROBE;
            st_q.addr     <= '0;
            st_q.stb      <= 1'b0;
            st_q.stb_addr <= '0;
            st_q.stb_byte <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_stb  = st_q.stb;
    assign wr_addr = st_q.stb_addr;
    assign wr_byte = st_q.stb_byte;

endmodule

// File: rtl/mbus_regs.sv
module mbus_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_STAGE = 3,
    parameter int ADDR_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_byte,
    output logic [BYTE_W*NUM_STAGE-1:0]   ctrl_word,
    output logic [BYTE_W*NUM_STAGE-1:0]   init_word
);

    localparam int REG_W = BYTE_W * NUM_STAGE;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_STAGE);
    localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(NUM_STAGE + 1);

    typedef struct packed {
        logic [NUM_STAGE-1:0][BYTE_W-1:0] stage;
        logic [REG_W-1:0]                 ctrl;
        logic [REG_W-1:0]                 init;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_stb) begin
            for (int i = 0; i < NUM_STAGE; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    rg_d.stage[i] = wr_byte;
                end
            end
            if (wr_addr == A_CTRL) begin
                rg_d.ctrl = rg_q.stage;
            end
            if (wr_addr == A_INIT) begin
                rg_d.init = rg_q.stage;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ctrl_word = rg_q.ctrl;
    assign init_word = rg_q.init;

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
    parameter int BYTE_W      = 8,
    parameter int NUM_STAGE   = 3,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BYTE_W-1:0]           ad,
    input  logic                        ale_as,
    input  logic                        rd_ds,
    input  logic                        wr_rw,
    input  logic                        cs_n,
    output logic [BYTE_W*NUM_STAGE-1:0] ctrl_word,
    output logic [BYTE_W*NUM_STAGE-1:0] init_word
);

    localparam int REG_W  = BYTE_W * NUM_STAGE;
    localparam int BUS_W  = BYTE_W + 4;
    localparam int A_CTRL = NUM_STAGE;
    localparam int A_INIT = NUM_STAGE + 1;
    localparam logic [BUS_W-1:0] BUS_IDLE = {{BYTE_W{1'b0}}, 4'b0111};

    logic [BUS_W-1:0]  bus_s;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_byte;

    mbus_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ad, ale_as, rd_ds, wr_rw, cs_n}),
        .dout  (bus_s)
    );

    mbus_decode #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ad_s    (bus_s[BUS_W-1:4]),
        .ale_s   (bus_s[3]),
        .rds_s   (bus_s[2]),
        .wrw_s   (bus_s[1]),
        .csn_s   (bus_s[0]),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_byte (wr_byte)
    );

    mbus_regs #(
        .BYTE_W    (BYTE_W),
        .NUM_STAGE (NUM_STAGE),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_byte   (wr_byte),
        .ctrl_word (ctrl_word),
        .init_word (init_word)
    );

endmodule

// File: rtl/mbus_regfile_chk.sv
module mbus_regfile_chk #(
    parameter int ADDR_W = 3,
    parameter int REG_W  = 24,
    parameter int A_CTRL = 3,
    parameter int A_INIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  ctrl_word,
    input logic [REG_W-1:0]  init_word
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_word == '0) && (init_word == '0)); // R9

    AST_CTRL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> $past(wr_stb && (wr_addr == ADDR_W'(A_CTRL)))); // R6

    AST_INIT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(init_word) |-> $past(wr_stb && (wr_addr == ADDR_W'(A_INIT)))); // R7

    AST_UNUSED_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (wr_addr > ADDR_W'(A_INIT))) |=> $stable(ctrl_word) && $stable(init_word)); // R8

    AST_ONE_WRITE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3

endmodule

bind mbus_regfile mbus_regfile_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .A_CTRL (A_CTRL),
    .A_INIT (A_INIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .ctrl_word (ctrl_word),
    .init_word (init_word)
);

// File: tb/mbus_regfile_test.sv
module mbus_regfile_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad = 8'h00;
    logic        ale_as = 1'b0;
    logic        rd_ds = 1'b1;
    logic        wr_rw = 1'b1;
    logic        cs_n = 1'b1;
    logic [23:0] ctrl_word;
    logic [23:0] init_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_stage [3];
    logic [23:0] m_ctrl;
    logic [23:0] m_init;

    mbus_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ad        (ad),
        .ale_as    (ale_as),
        .rd_ds     (rd_ds),
        .wr_rw     (wr_rw),
        .cs_n      (cs_n),
        .ctrl_word (ctrl_word),
        .init_word (init_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] packed_stage();
        return {m_stage[2], m_stage[1], m_stage[0]};
    endfunction

    // Reference model: effect of one bus cycle on the staging and committed words
    function automatic void model(input logic [2:0] a, input logic [7:0] dat,
                                  input bit sel, input bit rd_only);
        if (!sel || rd_only) return;
        case (a)
            3'd0, 3'd1, 3'd2: m_stage[a] = dat;
            3'd3: m_ctrl = packed_stage();
            3'd4: m_init = packed_stage();
            default: ;
        endcase
    endfunction

    // One bus cycle; strobe=1 uses write strobe timing, else data strobe timing
    task automatic bus_cycle(input bit strobe, input logic [7:0] abyte,
                             input logic [7:0] dat, input bit sel, input bit rd_only);
        cs_n   = 1'b1;
        ale_as = 1'b0;
        if (strobe) begin
            rd_ds = 1'b1;
            wr_rw = 1'b1;
        end else begin
            rd_ds = 1'b0;
            wr_rw = rd_only;
        end
        idle(4);
        ad = abyte;
        ale_as = 1'b1;
        idle(4);
        ale_as = 1'b0;
        idle(4);
        ad = dat;
        cs_n = !sel;
        idle(2);
        if (strobe) begin
            if (rd_only) begin
                rd_ds = 1'b0;
                idle(4);
                rd_ds = 1'b1;
            end else begin
                wr_rw = 1'b0;
                idle(4);
                wr_rw = 1'b1;
            end
        end else begin
            rd_ds = 1'b1;
            idle(4);
            rd_ds = 1'b0;
        end
        idle(4);
        cs_n = 1'b1;
        wr_rw = strobe ? 1'b1 : 1'b0;
        idle(8);
        model(abyte[2:0], dat, sel, rd_only);
    endtask

    task automatic cmp_both(input string tag);
        chk(tag, ctrl_word, m_ctrl);
        chk(tag, init_word, m_init);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) m_stage[i] = 8'h00;
        m_ctrl = '0;
        m_init = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9: reset state of both words
        chk("R9 ctrl after reset", ctrl_word, 24'h0);
        chk("R9 init after reset", init_word, 24'h0);
        // R9: staging also cleared, commit before any staging write gives zero
        bus_cycle(1'b1, 8'h03, 8'hA5, 1'b1, 1'b0);
        chk("R9 staging cleared by reset", ctrl_word, 24'h0);

        // R5: staging writes invisible until commit; strobe mode
        bus_cycle(1'b1, 8'h00, 8'h11, 1'b1, 1'b0);
        bus_cycle(1'b1, 8'h01, 8'h22, 1'b1, 1'b0);
        bus_cycle(1'b1, 8'h02, 8'h33, 1'b1, 1'b0);
        chk("R5 staging hidden ctrl", ctrl_word, 24'h0);
        chk("R5 staging hidden init", init_word, 24'h0);

        // R6: commit control, data byte ignored, byte order
        bus_cycle(1'b1, 8'h03, 8'hFF, 1'b1, 1'b0);
        chk("R6 ctrl commit", ctrl_word, 24'h332211);
        chk("R6 init untouched", init_word, 24'h0);

        // R7 + R1: data-strobe cycle right after strobe cycles, staging kept
        bus_cycle(1'b0, 8'h04, 8'h00, 1'b1, 1'b0);
        chk("R7 init commit keeps staging", init_word, 24'h332211);

        // R4: data-strobe mode writes a byte
        bus_cycle(1'b0, 8'h01, 8'h5A, 1'b1, 1'b0);
        bus_cycle(1'b0, 8'h03, 8'h77, 1'b1, 1'b0);
        chk("R4 data strobe write", ctrl_word, 24'h335A11);

        // R2: upper address bits ignored (0xF8 decodes as address 0)
        bus_cycle(1'b1, 8'hF8, 8'hC3, 1'b1, 1'b0);
        bus_cycle(1'b0, 8'hEB, 8'h00, 1'b1, 1'b0);
        chk("R2 upper address bits", ctrl_word, 24'h335AC3);

        // R3: read pulse in strobe mode writes nothing
        bus_cycle(1'b1, 8'h02, 8'h99, 1'b1, 1'b1);
        bus_cycle(1'b1, 8'h03, 8'h00, 1'b1, 1'b0);
        chk("R3 read pulse ignored", ctrl_word, 24'h335AC3);

        // R4: read/not-write high in data-strobe mode writes nothing
        bus_cycle(1'b0, 8'h00, 8'h44, 1'b1, 1'b1);
        bus_cycle(1'b0, 8'h04, 8'h00, 1'b1, 1'b0);
        chk("R4 read select ignored", init_word, 24'h335AC3);

        // R8: chip select inactive and addresses 5..7
        bus_cycle(1'b1, 8'h01, 8'hEE, 1'b0, 1'b0);
        bus_cycle(1'b0, 8'h03, 8'h00, 1'b0, 1'b0);
        bus_cycle(1'b1, 8'h05, 8'h12, 1'b1, 1'b0);
        bus_cycle(1'b0, 8'h06, 8'h34, 1'b1, 1'b0);
        bus_cycle(1'b1, 8'h07, 8'h56, 1'b1, 1'b0);
        cmp_both("R8 no effect");
        bus_cycle(1'b1, 8'h03, 8'h00, 1'b1, 1'b0);
        chk("R8 staging unchanged", ctrl_word, 24'h335AC3);

        // R1: random mix of conventions, addresses and ignored cycles
        for (int n = 0; n < 300; n++) begin
            bit strobe_m = 1'($urandom % 2);
            logic [7:0] abyte = 8'($urandom);
            bit sel = ($urandom % 8) != 0;
            bit rd_only = ($urandom % 6) == 0;
            logic [7:0] dat = 8'($urandom);
            if ($urandom % 3 == 0) abyte[2:0] = 3'd3 + 3'($urandom % 2);
            bus_cycle(strobe_m, abyte, dat, sel, rd_only);
            cmp_both("R1 random cycle");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule